// File: doc/BRIEF.md
# Quad-byte video pixel ALU

This block is a SIMD arithmetic unit for pixel work. It treats each 32-bit operand as four unsigned byte lanes and applies one operation to all lanes at once. The operations are: clipping adds on bytes or on 16-bit halves, rounded or truncated averages, a per-lane absolute difference that also feeds four running 16-bit sums for block matching, and a byte-granular extract from a two-word window, used to realign unaligned pixel rows.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, one cycle after acceptance. A single output register sits between them. A new operation is accepted when that register is empty or is being drained in the same cycle. If the consumer holds `out_ready` low, the held result stays unchanged and `in_ready` falls. The accumulator clear is a plain control pin, and it acts whether or not an operation is being accepted.

Top module: `pixel_quad_alu`

## Requirements
- R1: With op code 0, each byte lane returns the unsigned sum a+b, clipped to 255 (0xFF).
- R2: With op code 1, each 16-bit half (bits 31:16 and 15:0) returns the unsigned sum, clipped to 0xFFFF.
- R3: With op code 2, each byte lane returns (a+b+1)>>1 when `rnd_i` is 1 and (a+b)>>1 when it is 0.
- R4: With op code 3, each byte lane of the result is |a−b|, and that value is added into the accumulator field of the same lane. Lane i occupies bits 16i+15:16i of `acc_o`.
- R5: Each accumulator field saturates at 0xFFFF and never wraps. A lane whose difference is zero keeps its value.
- R6: While `acc_clr_i` is 1, all accumulator fields become zero on the next edge. A clear in the same cycle as an accepted op code 3 wins over that op's accumulation.
- R7: With op code 4, the result is bytes off..off+3 of the 64-bit window {src_b_i, src_a_i}, where byte 0 is src_a_i[7:0]. So off=0 returns src_a_i.
- R8: Op codes 5 to 7 produce a zero result and leave the accumulator unchanged.
- R9: An op accepted when `in_valid` and `in_ready` are both 1 appears on `result_o` with `out_valid` one cycle later. `in_ready` equals !out_valid || out_ready. While `out_valid` is 1 and `out_ready` is 0, `result_o` holds and no new op is taken.
- R10: After reset, `out_valid` is 0, `result_o` is 0 and every accumulator field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| op_i | input | 3 | Operation code |
| rnd_i | input | 1 | Rounding select for averages |
| align_off_i | input | 2 | Byte offset for the alignment extract |
| src_a_i | input | 32 | First operand, low word of the alignment window |
| src_b_i | input | 32 | Second operand, high word of the alignment window |
| acc_clr_i | input | 1 | Zero all accumulator fields |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| result_o | output | 32 | Registered result |
| acc_o | output | 64 | Four 16-bit accumulator fields, lane 0 lowest |

## Verification
The bench builds the block with its defaults: four lanes of 8 bits and 16-bit accumulator fields. With these values, a lane difference of 0xFF reaches the 0xFFFF limit after exactly 257 accumulations, so saturation is reached within a few hundred cycles. Every alignment offset of the two-word window can also be covered with a handful of vectors. The 16-bit halves line up with pairs of byte lanes, so carries inside a half and clipping of a half are both visible in a single result word.

// File: rtl/pqa_pkg.sv
package pqa_pkg;
  typedef enum logic [2:0] {
    OP_ADD8  = 3'd0,
    OP_ADD16 = 3'd1,
    OP_AVG   = 3'd2,
    OP_SAD   = 3'd3,
    OP_ALIGN = 3'd4
  } pqa_op_e;
endpackage

// File: rtl/pqa_sat_add.sv
// Unsigned add clipped at the all-ones value of the lane width.
module pqa_sat_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] raw;
  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    sum = raw[W] ? {W{1'b1}} : raw[W-1:0];
  end
endmodule

// File: rtl/pqa_lane_avg_diff.sv
// Per-lane average (optionally rounded) and absolute difference.
module pqa_lane_avg_diff #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rnd,
  output logic [W-1:0] avg,
  output logic [W-1:0] absdiff
);
  logic [W:0] total;
  always_comb begin
    total   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, rnd};
    avg     = total[W:1];
    absdiff = (a >= b) ? (a - b) : (b - a);
  end
endmodule

// File: rtl/pqa_byte_align.sv
// Picks LANES consecutive bytes out of a two-word window.
module pqa_byte_align #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int OFF_W  = 2
) (
  input  logic [LANES*LANE_W-1:0] lo,
  input  logic [LANES*LANE_W-1:0] hi,
  input  logic [OFF_W-1:0]        off,
  output logic [LANES*LANE_W-1:0] out
);
  localparam int NB = 2 * LANES;
  logic [NB*LANE_W-1:0] window;

  always_comb begin
    window = {hi, lo};
    out    = '0;
    for (int i = 0; i < LANES; i++) begin
      out[i*LANE_W +: LANE_W] = window[(int'(off) + i)*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/pqa_sad_accum.sv
// Per-lane saturating accumulators for absolute differences.
module pqa_sad_accum #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     clr,
  input  logic [LANES*LANE_W-1:0]  diff,
  output logic [LANES*ACC_W-1:0]   acc
);
  logic [ACC_W-1:0] acc_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_acc
    logic [ACC_W:0] nxt;
    always_comb begin
      nxt = {1'b0, acc_q[l]} + (ACC_W+1)'(diff[l*LANE_W +: LANE_W]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        acc_q[l] <= '0;
      end else if (en) begin
        acc_q[l] <= nxt[ACC_W] ? {ACC_W{1'b1}} : nxt[ACC_W-1:0];
      end
    end

    assign acc[l*ACC_W +: ACC_W] = acc_q[l];

    // R5: without a clear a field never decreases (no wrap)
    a_r5_acc_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> acc_q[l] >= $past(acc_q[l]));

    // R6: a clear leaves the field at zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc_q[l] == '0);
  end
endmodule

// File: rtl/pixel_quad_alu.sv
module pixel_quad_alu
  import pqa_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [2:0]               op_i,
  input  logic                     rnd_i,
  input  logic [$clog2(LANES)-1:0] align_off_i,
  input  logic [LANES*LANE_W-1:0]  src_a_i,
  input  logic [LANES*LANE_W-1:0]  src_b_i,
  input  logic                     acc_clr_i,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*LANE_W-1:0]  result_o,
  output logic [LANES*ACC_W-1:0]   acc_o
);
  localparam int DW     = LANES * LANE_W;
  localparam int HW     = 2 * LANE_W;
  localparam int HALVES = LANES / 2;
  localparam int OFF_W  = $clog2(LANES);

  logic [DW-1:0] add8_res, add16_res, avg_res, diff_res, align_res;
  logic [DW-1:0] nxt_res;
  logic          accept;
  pqa_op_e       op;

  assign op = pqa_op_e'(op_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pqa_sat_add #(.W(LANE_W)) u_add8 (
      .a   (src_a_i[l*LANE_W +: LANE_W]),
      .b   (src_b_i[l*LANE_W +: LANE_W]),
      .sum (add8_res[l*LANE_W +: LANE_W])
    );
    pqa_lane_avg_diff #(.W(LANE_W)) u_avgdiff (
      .a       (src_a_i[l*LANE_W +: LANE_W]),
      .b       (src_b_i[l*LANE_W +: LANE_W]),
      .rnd     (rnd_i),
      .avg     (avg_res[l*LANE_W +: LANE_W]),
      .absdiff (diff_res[l*LANE_W +: LANE_W])
    );
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    pqa_sat_add #(.W(HW)) u_add16 (
      .a   (src_a_i[h*HW +: HW]),
      .b   (src_b_i[h*HW +: HW]),
      .sum (add16_res[h*HW +: HW])
    );
  end
  if (LANES % 2 != 0) begin : g_odd
    assign add16_res[DW-1 -: LANE_W] = '0;
  end

  pqa_byte_align #(.LANES(LANES), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_align (
    .lo  (src_a_i),
    .hi  (src_b_i),
    .off (align_off_i),
    .out (align_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD8:  nxt_res = add8_res;
      OP_ADD16: nxt_res = add16_res;
      OP_AVG:   nxt_res = avg_res;
      OP_SAD:   nxt_res = diff_res;
      OP_ALIGN: nxt_res = align_res;
      default:  nxt_res = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result_o  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result_o  <= nxt_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  pqa_sad_accum #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (accept && (op == OP_SAD)),
    .clr   (acc_clr_i),
    .diff  (diff_res),
    .acc   (acc_o)
  );

  // R9: an accepted op yields valid output on the next cycle
  a_r9_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: a stalled result is held
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result_o));

  // R8: reserved codes do not touch the accumulator
  a_r8_reserved_acc: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op_i > 3'd4) && !acc_clr_i |=> $stable(acc_o));

  // R8: reserved codes give a zero result
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op_i > 3'd4) |=> result_o == '0);
endmodule

// File: tb/pixel_quad_alu_tb_top.sv
`timescale 1ns/1ps
module pixel_quad_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, rnd_i, acc_clr_i, out_valid, out_ready;
  logic [2:0]  op_i;
  logic [1:0]  align_off_i;
  logic [31:0] src_a_i, src_b_i, result_o;
  logic [63:0] acc_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pixel_quad_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_i(op_i), .rnd_i(rnd_i), .align_off_i(align_off_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_clr_i(acc_clr_i),
    .out_valid(out_valid), .out_ready(out_ready),
    .result_o(result_o), .acc_o(acc_o)
  );

  localparam int NV = 11;
  localparam logic [2:0]  V_OP  [NV] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd3,
                                         3'd4, 3'd4, 3'd4, 3'd4, 3'd5};
  localparam logic        V_RND [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                                         1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0]  V_OFF [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
                                         2'd0, 2'd1, 2'd3, 2'd2, 2'd0};
  localparam logic [31:0] V_A   [NV] = '{32'h10203040, 32'hFF807F00, 32'hFFF01234,
                                         32'h01FF1003, 32'h01FF1003, 32'h0500FF80,
                                         32'h33221100, 32'h33221100, 32'h33221100,
                                         32'h33221100, 32'h12345678};
  localparam logic [31:0] V_B   [NV] = '{32'h01020304, 32'h01808000, 32'h00200001,
                                         32'h02FF2000, 32'h02FF2000, 32'h020A0080,
                                         32'h77665544, 32'h77665544, 32'h77665544,
                                         32'h77665544, 32'h9ABCDEF0};
  localparam logic [31:0] V_EXP [NV] = '{32'h11223344, 32'hFFFFFF00, 32'hFFFF1235,
                                         32'h01FF1801, 32'h02FF1802, 32'h030AFF00,
                                         32'h33221100, 32'h44332211, 32'h66554433,
                                         32'h55443322, 32'h00000000};

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic rnd, input logic [1:0] off,
                      input logic [31:0] a, input logic [31:0] b, input logic clr);
    @(negedge clk);
    op_i = op; rnd_i = rnd; align_off_i = off; src_a_i = a; src_b_i = b;
    acc_clr_i = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; acc_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 1; acc_clr_i = 0;
    op_i = 0; rnd_i = 0; align_off_i = 0; src_a_i = 0; src_b_i = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {63'd0, out_valid}, 64'd0);
    chk("R10", {32'd0, result_o}, 64'd0);
    chk("R10", acc_o, 64'd0);
    chk("R9", {63'd0, in_ready}, 64'd1);
    rst_n = 1;

    // Vector table walk; each result visible one cycle after acceptance (R9)
    for (int i = 0; i < NV; i++) begin
      send(V_OP[i], V_RND[i], V_OFF[i], V_A[i], V_B[i], 1'b0);
      chk(req_of(V_OP[i]), {32'd0, result_o}, {32'd0, V_EXP[i]});
      chk("R9", {63'd0, out_valid}, 64'd1);
    end
    // R4 one SAD accumulated; R8 reserved op afterwards left it alone
    chk("R4", acc_o, 64'h0003_000A_00FF_0000);

    // R6 clear together with a SAD op: clear wins
    send(3'd3, 0, 0, 32'hFFFFFFFF, 32'h00000000, 1'b1);
    chk("R6", acc_o, 64'd0);

    // R5 saturation and lane independence
    send(3'd3, 0, 0, 32'hFFFFFF00, 32'h00000000, 1'b0);
    chk("R5", acc_o, 64'h00FF_00FF_00FF_0000);
    for (int k = 0; k < 259; k++) send(3'd3, 0, 0, 32'hFFFFFF00, 32'h00000000, 1'b0);
    chk("R5", acc_o, 64'hFFFF_FFFF_FFFF_0000);

    // R6 clear without an operation
    @(negedge clk); acc_clr_i = 1;
    @(negedge clk); acc_clr_i = 0;
    chk("R6", acc_o, 64'd0);

    // R9 back-pressure
    out_ready = 0;
    send(3'd0, 0, 0, 32'h01010101, 32'h01010101, 1'b0);
    chk("R9", {32'd0, result_o}, 64'h02020202);
    chk("R9", {63'd0, in_ready}, 64'd0);
    op_i = 3'd0; src_a_i = 32'h05050505; src_b_i = 32'h05050505; in_valid = 1;
    repeat (2) @(negedge clk);
    chk("R9", {32'd0, result_o}, 64'h02020202);
    chk("R9", {63'd0, out_valid}, 64'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R9", {32'd0, result_o}, 64'h0A0A0A0A);
    @(negedge clk);
    chk("R9", {63'd0, out_valid}, 64'd0);

    finish_run();
  end
endmodule